// File: doc/BRIEF.md
# Dual-Issue Scoreboard Issue Controller

This block is the issue stage of an in-order-issue, out-of-order-completion superscalar core. Each cycle it looks at up to two decoded instructions, an older one and a younger one. Each instruction carries a destination register, two source registers, a unit class (integer or floating point) and a latency in cycles. The block decides whether none, the older only, or both may start execution. It sends one start strobe to each of its execution units: a configurable number of integer units and a single floating-point unit.

A register scoreboard keeps two things for every architectural register: a pending bit and a count of the cycles left until the latest in-flight writer of that register completes. A per-unit busy counter models units that cannot accept new work until their current operation has finished. Completion write-back pulses release scoreboard entries. A pulse releases an entry only when it belongs to the latest writer, which is when the entry's counter has reached zero. A pulse in the same cycle as a dependent instruction counts as a bypass.

The upstream decode stage is expected to keep any instruction that did not issue and present it again. The block has no holding storage of its own.

Top module: `dual_issue_ctrl`

## Requirements
- R1: The younger slot issues only in a cycle in which the older slot also issues.
- R2: A slot does not issue while either of its source registers is pending. This includes a source that equals the destination of the older slot issuing in the same cycle.
- R3: A write-back pulse for a register whose remaining-cycle count is zero releases that register in the same cycle. A dependent instruction may issue in that cycle.
- R4: There is one floating-point unit. When both slots need it, only the older slot is granted it. A floating-point instruction stalls while that unit is busy.
- R5: An instruction with latency L keeps its unit busy for the L-1 cycles after issue. During that time no other instruction is started on that unit.
- R6: Latency is at least 1. An instruction whose destination has an in-flight writer with a remaining count at least equal to the new latency does not issue. It issues when its latency is strictly larger.
- R7: The younger slot does not issue when it writes the same register as the older slot and its latency is not strictly larger than the older slot's latency.
- R8: Integer work goes to the lowest-numbered free integer unit. The older slot picks first. Bit i of `int_from_young` is 0 when unit i was started by the older slot and 1 when it was started by the younger slot. `fp_from_young` uses the same encoding.
- R9: Every issued instruction raises exactly one unit strobe. No strobe goes to a busy unit, so the work in execution never exceeds the number of units.
- R10: After reset no register is pending and every unit is free.
- R11: A write-back pulse that arrives while the register's remaining count is non-zero comes from a superseded writer. It leaves the register pending.
- R12: When the older slot is not valid, nothing issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_valid | input | 1 | Older slot holds an instruction |
| s0_dst | input | REG_W | Older slot destination register |
| s0_src_a | input | REG_W | Older slot first source register |
| s0_src_b | input | REG_W | Older slot second source register |
| s0_is_fp | input | 1 | Older slot needs the floating-point unit |
| s0_lat | input | LAT_W | Older slot latency in cycles (at least 1) |
| s1_valid | input | 1 | Younger slot holds an instruction |
| s1_dst | input | REG_W | Younger slot destination register |
| s1_src_a | input | REG_W | Younger slot first source register |
| s1_src_b | input | REG_W | Younger slot second source register |
| s1_is_fp | input | 1 | Younger slot needs the floating-point unit |
| s1_lat | input | LAT_W | Younger slot latency in cycles (at least 1) |
| wb_valid | input | NUM_WB | Write-back pulse per completion port |
| wb_reg | input | NUM_WB*REG_W | Register written by each completion port |
| issue0 | output | 1 | Older slot issues this cycle |
| issue1 | output | 1 | Younger slot issues this cycle |
| int_go | output | NUM_INT | Start strobe per integer unit |
| int_from_young | output | NUM_INT | Per integer unit: started by the younger slot |
| fp_go | output | 1 | Start strobe for the floating-point unit |
| fp_from_young | output | 1 | Floating-point unit started by the younger slot |

## Verification
Some properties are checked on every cycle: that an issued older instruction never reads a pending register or violates write ordering against an in-flight writer, that no strobe reaches a busy unit and each issue yields exactly one strobe, that a multi-cycle unit stays busy after it starts, and that a scoreboard entry with cycles remaining cannot be released. Other behaviour is shown only by the bench's scenario sequence: bypass timing on a same-cycle write-back, which unit the allocator picks and how the younger slot is encoded, hazards inside the pair, the superseded-writer pulse, and the whole chain of in-order stalls.

// File: rtl/dic_pkg.sv
package dic_pkg;

   // Which slot of the issue pair started a unit.
   typedef enum logic {
      SLOT_OLDER   = 1'b0,
      SLOT_YOUNGER = 1'b1
   } slot_sel_e;

   // Remaining cycles stored after issue: latency minus one.
   function automatic logic [15:0] lat_to_cnt(input logic [15:0] lat);
      return (lat == 16'd0) ? 16'd0 : lat - 16'd1;
   endfunction

endpackage

// File: rtl/dic_scoreboard.sv
module dic_scoreboard #(
   parameter int NUM_REGS = 32,
   parameter int LAT_W    = 4,
   parameter int NUM_WB   = 3,
   localparam int REG_W   = $clog2(NUM_REGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      set0,
   input  logic [REG_W-1:0]          dst0,
   input  logic [LAT_W-1:0]          lat0,
   input  logic                      set1,
   input  logic [REG_W-1:0]          dst1,
   input  logic [LAT_W-1:0]          lat1,
   input  logic [NUM_WB-1:0]         wb_valid,
   input  logic [NUM_WB*REG_W-1:0]   wb_reg,
   output logic [NUM_REGS-1:0]       pending,
   output logic [NUM_REGS-1:0]       pend_eff,
   output logic [LAT_W-1:0]          remain [NUM_REGS]
);
   import dic_pkg::*;

   if (NUM_REGS < 2) begin : g_bad_regs
      $error("dic_scoreboard: NUM_REGS must be at least 2");
   end
   if (LAT_W < 1 || LAT_W > 16) begin : g_bad_lat
      $error("dic_scoreboard: LAT_W must be within 1..16");
   end

   logic [LAT_W-1:0] cnt_new0, cnt_new1;
   assign cnt_new0 = LAT_W'(lat_to_cnt(16'(lat0)));
   assign cnt_new1 = LAT_W'(lat_to_cnt(16'(lat1)));

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_entry
      logic             pend_q;
      logic [LAT_W-1:0] rem_q;
      logic             wb_hit;
      logic             release_now;
      logic             hit0, hit1;

      always_comb begin
         wb_hit = 1'b0;
         for (int k = 0; k < NUM_WB; k++) begin
            if (wb_valid[k] && (wb_reg[k*REG_W +: REG_W] == REG_W'(r))) begin
               wb_hit = 1'b1;
            end
         end
      end

      assign release_now = pend_q && wb_hit && (rem_q == '0);
      assign hit0 = set0 && (dst0 == REG_W'(r));
      assign hit1 = set1 && (dst1 == REG_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            rem_q  <= '0;
         end else if (hit1) begin
            pend_q <= 1'b1;
            rem_q  <= cnt_new1;
         end else if (hit0) begin
            pend_q <= 1'b1;
            rem_q  <= cnt_new0;
         end else begin
            if (release_now) begin
               pend_q <= 1'b0;
            end
            if (rem_q != '0) begin
               rem_q <= rem_q - 1'b1;
            end
         end
      end

      assign pending[r]  = pend_q;
      assign pend_eff[r] = pend_q && !release_now;
      assign remain[r]   = rem_q;

      // A pulse from a superseded writer must not free the entry.
      assert_no_early_release_R11 : assert property (
         @(posedge clk) disable iff (!rst_n)
         (pend_q && (rem_q != '0)) |=> pend_q)
         else $error("entry %0d released while cycles remained", r);
   end

endmodule

// File: rtl/dic_units.sv
module dic_units #(
   parameter int NUM_UNITS = 3,
   parameter int LAT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_UNITS-1:0] go,
   input  logic [LAT_W-1:0] lat [NUM_UNITS],
   output logic [NUM_UNITS-1:0] busy
);
   import dic_pkg::*;

   if (NUM_UNITS < 2) begin : g_bad_units
      $error("dic_units: at least two units are required");
   end

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic [LAT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (go[u]) begin
            cnt_q <= LAT_W'(lat_to_cnt(16'(lat[u])));
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign busy[u] = (cnt_q != '0);

      assert_no_busy_start_R9 : assert property (
         @(posedge clk) disable iff (!rst_n)
         go[u] |-> !busy[u])
         else $error("unit %0d started while busy", u);

      assert_multicycle_hold_R5 : assert property (
         @(posedge clk) disable iff (!rst_n)
         (go[u] && (lat[u] > LAT_W'(1))) |=> busy[u])
         else $error("unit %0d free right after a multi-cycle start", u);
   end

endmodule

// File: rtl/dic_issue_logic.sv
module dic_issue_logic #(
   parameter int NUM_REGS = 32,
   parameter int LAT_W    = 4,
   parameter int NUM_INT  = 2,
   localparam int REG_W     = $clog2(NUM_REGS),
   localparam int NUM_UNITS = NUM_INT + 1,
   localparam int FPU       = NUM_INT,
   localparam int UIDX_W    = $clog2(NUM_UNITS)
) (
   input  logic                 v0,
   input  logic [REG_W-1:0]     d0,
   input  logic [REG_W-1:0]     a0,
   input  logic [REG_W-1:0]     b0,
   input  logic                 fp0,
   input  logic [LAT_W-1:0]     l0,
   input  logic                 v1,
   input  logic [REG_W-1:0]     d1,
   input  logic [REG_W-1:0]     a1,
   input  logic [REG_W-1:0]     b1,
   input  logic                 fp1,
   input  logic [LAT_W-1:0]     l1,
   input  logic [NUM_REGS-1:0]  pending,
   input  logic [NUM_REGS-1:0]  pend_eff,
   input  logic [LAT_W-1:0]     remain [NUM_REGS],
   input  logic [NUM_UNITS-1:0] busy,
   output logic                 iss0,
   output logic                 iss1,
   output logic [NUM_UNITS-1:0] unit_go,
   output logic [NUM_UNITS-1:0] unit_young,
   output logic [LAT_W-1:0]     unit_lat [NUM_UNITS]
);
   import dic_pkg::*;

   logic              raw0, waw0, unit_ok0, ok0;
   logic              raw1, waw1, unit_ok1, ok1;
   logic              has_a, has_b;
   logic [UIDX_W-1:0] free_a, free_b;

   // First and second free integer units, lowest index first.
   always_comb begin
      has_a  = 1'b0;
      has_b  = 1'b0;
      free_a = '0;
      free_b = '0;
      for (int i = 0; i < NUM_INT; i++) begin
         if (!busy[i] && !has_a) begin
            has_a  = 1'b1;
            free_a = UIDX_W'(i);
         end else if (!busy[i] && !has_b) begin
            has_b  = 1'b1;
            free_b = UIDX_W'(i);
         end
      end
   end

   // Older slot.
   always_comb begin
      raw0     = pend_eff[a0] || pend_eff[b0];
      waw0     = pending[d0] && (remain[d0] >= l0);
      unit_ok0 = fp0 ? !busy[FPU] : has_a;
      ok0      = v0 && !raw0 && !waw0 && unit_ok0;
   end

   // Younger slot: checked against the scoreboard and the older slot.
   always_comb begin
      raw1 = pend_eff[a1] || pend_eff[b1] || (a1 == d0) || (b1 == d0);
      waw1 = (pending[d1] && (remain[d1] >= l1)) ||
             ((d1 == d0) && (l0 >= l1));
      if (fp1) begin
         unit_ok1 = !busy[FPU] && !fp0;
      end else begin
         unit_ok1 = fp0 ? has_a : has_b;
      end
      ok1 = ok0 && v1 && !raw1 && !waw1 && unit_ok1;
   end

   assign iss0 = ok0;
   assign iss1 = ok1;

   always_comb begin
      unit_go    = '0;
      unit_young = '0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         unit_lat[u] = '0;
      end
      if (ok0) begin
         if (fp0) begin
            unit_go[FPU]    = 1'b1;
            unit_young[FPU] = SLOT_OLDER;
            unit_lat[FPU]   = l0;
         end else begin
            unit_go[free_a]    = 1'b1;
            unit_young[free_a] = SLOT_OLDER;
            unit_lat[free_a]   = l0;
         end
      end
      if (ok1) begin
         if (fp1) begin
            unit_go[FPU]    = 1'b1;
            unit_young[FPU] = SLOT_YOUNGER;
            unit_lat[FPU]   = l1;
         end else if (fp0) begin
            unit_go[free_a]    = 1'b1;
            unit_young[free_a] = SLOT_YOUNGER;
            unit_lat[free_a]   = l1;
         end else begin
            unit_go[free_b]    = 1'b1;
            unit_young[free_b] = SLOT_YOUNGER;
            unit_lat[free_b]   = l1;
         end
      end
   end

endmodule

// File: rtl/dual_issue_ctrl.sv
module dual_issue_ctrl #(
   parameter int NUM_REGS = 32,
   parameter int LAT_W    = 4,
   parameter int NUM_INT  = 2,
   localparam int REG_W     = $clog2(NUM_REGS),
   localparam int NUM_UNITS = NUM_INT + 1,
   localparam int NUM_WB    = NUM_UNITS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     s0_valid,
   input  logic [REG_W-1:0]         s0_dst,
   input  logic [REG_W-1:0]         s0_src_a,
   input  logic [REG_W-1:0]         s0_src_b,
   input  logic                     s0_is_fp,
   input  logic [LAT_W-1:0]         s0_lat,
   input  logic                     s1_valid,
   input  logic [REG_W-1:0]         s1_dst,
   input  logic [REG_W-1:0]         s1_src_a,
   input  logic [REG_W-1:0]         s1_src_b,
   input  logic                     s1_is_fp,
   input  logic [LAT_W-1:0]         s1_lat,
   input  logic [NUM_WB-1:0]        wb_valid,
   input  logic [NUM_WB*REG_W-1:0]  wb_reg,
   output logic                     issue0,
   output logic                     issue1,
   output logic [NUM_INT-1:0]       int_go,
   output logic [NUM_INT-1:0]       int_from_young,
   output logic                     fp_go,
   output logic                     fp_from_young
);

   if (NUM_INT < 1 || NUM_INT > 8) begin : g_bad_int
      $error("dual_issue_ctrl: NUM_INT must be within 1..8");
   end
   if ((1 << REG_W) != NUM_REGS) begin : g_bad_pow2
      $error("dual_issue_ctrl: NUM_REGS must be a power of two");
   end

   logic [NUM_REGS-1:0]  pending, pend_eff;
   logic [LAT_W-1:0]     remain   [NUM_REGS];
   logic [NUM_UNITS-1:0] busy, unit_go, unit_young;
   logic [LAT_W-1:0]     unit_lat [NUM_UNITS];

   dic_scoreboard #(
      .NUM_REGS (NUM_REGS),
      .LAT_W    (LAT_W),
      .NUM_WB   (NUM_WB)
   ) i_scoreboard (
      .clk      (clk),
      .rst_n    (rst_n),
      .set0     (issue0),
      .dst0     (s0_dst),
      .lat0     (s0_lat),
      .set1     (issue1),
      .dst1     (s1_dst),
      .lat1     (s1_lat),
      .wb_valid (wb_valid),
      .wb_reg   (wb_reg),
      .pending  (pending),
      .pend_eff (pend_eff),
      .remain   (remain)
   );

   dic_units #(
      .NUM_UNITS (NUM_UNITS),
      .LAT_W     (LAT_W)
   ) i_units (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (unit_go),
      .lat   (unit_lat),
      .busy  (busy)
   );

   dic_issue_logic #(
      .NUM_REGS (NUM_REGS),
      .LAT_W    (LAT_W),
      .NUM_INT  (NUM_INT)
   ) i_issue (
      .v0         (s0_valid),
      .d0         (s0_dst),
      .a0         (s0_src_a),
      .b0         (s0_src_b),
      .fp0        (s0_is_fp),
      .l0         (s0_lat),
      .v1         (s1_valid),
      .d1         (s1_dst),
      .a1         (s1_src_a),
      .b1         (s1_src_b),
      .fp1        (s1_is_fp),
      .l1         (s1_lat),
      .pending    (pending),
      .pend_eff   (pend_eff),
      .remain     (remain),
      .busy       (busy),
      .iss0       (issue0),
      .iss1       (issue1),
      .unit_go    (unit_go),
      .unit_young (unit_young),
      .unit_lat   (unit_lat)
   );

   assign int_go         = unit_go[NUM_INT-1:0];
   assign int_from_young = unit_young[NUM_INT-1:0];
   assign fp_go          = unit_go[NUM_INT];
   assign fp_from_young  = unit_young[NUM_INT];

   assert_raw_clear_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      issue0 |-> (!pend_eff[s0_src_a] && !pend_eff[s0_src_b]))
      else $error("older slot issued with a pending source");

   assert_waw_order_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      issue0 |-> !(pending[s0_dst] && (remain[s0_dst] >= s0_lat)))
      else $error("older slot would overtake an in-flight writer");

   assert_lat_nonzero_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      s0_valid |-> (s0_lat != '0))
      else $error("zero latency presented on the older slot");

   assert_one_strobe_R9 : assert property (
      @(posedge clk) disable iff (!rst_n)
      $countones(unit_go) == (32'(issue0) + 32'(issue1)))
      else $error("strobe count differs from issued instructions");

endmodule

// File: tb/test_dual_issue_ctrl.sv
`timescale 1ns/1ps
module test_dual_issue_ctrl;

   typedef struct packed {
      logic       v;
      logic [4:0] d;
      logic [4:0] a;
      logic [4:0] b;
      logic       fp;
      logic [3:0] lat;
   } slot_t;

   typedef struct {
      logic       i0;
      logic       i1;
      logic [1:0] ig;
      logic [1:0] iy;
      logic       fg;
      logic       fy;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   slot_t       s0, s1;
   logic [2:0]  wb_valid;
   logic [14:0] wb_reg;
   logic        issue0, issue1, fp_go, fp_from_young;
   logic [1:0]  int_go, int_from_young;

   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;
   exp_t q[$];

   always #2 clk = ~clk;

   dual_issue_ctrl i_dual_issue_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .s0_valid       (s0.v),
      .s0_dst         (s0.d),
      .s0_src_a       (s0.a),
      .s0_src_b       (s0.b),
      .s0_is_fp       (s0.fp),
      .s0_lat         (s0.lat),
      .s1_valid       (s1.v),
      .s1_dst         (s1.d),
      .s1_src_a       (s1.a),
      .s1_src_b       (s1.b),
      .s1_is_fp       (s1.fp),
      .s1_lat         (s1.lat),
      .wb_valid       (wb_valid),
      .wb_reg         (wb_reg),
      .issue0         (issue0),
      .issue1         (issue1),
      .int_go         (int_go),
      .int_from_young (int_from_young),
      .fp_go          (fp_go),
      .fp_from_young  (fp_from_young)
   );

   function automatic slot_t mk(input logic v, input int d, input int a, input int b,
                                input logic fp, input int lat);
      slot_t s;
      s.v = v; s.d = 5'(d); s.a = 5'(a); s.b = 5'(b); s.fp = fp; s.lat = 4'(lat);
      return s;
   endfunction

   function automatic exp_t ex(input logic i0, input logic i1, input logic [1:0] ig,
                               input logic [1:0] iy, input logic fg, input logic fy,
                               input string tag);
      exp_t e;
      e.i0 = i0; e.i1 = i1; e.ig = ig; e.iy = iy; e.fg = fg; e.fy = fy; e.tag = tag;
      return e;
   endfunction

   // Driver: one issue cycle, pushes the expected outcome.
   task automatic step(input slot_t a, input slot_t b, input logic [2:0] wv,
                       input int w0, input int w1, input int w2, input exp_t e);
      @(posedge clk);
      #1;
      s0 = a;
      s1 = b;
      wb_valid = wv;
      wb_reg = {5'(w2), 5'(w1), 5'(w0)};
      q.push_back(e);
   endtask

   // Monitor: compares in the middle of the cycle.
   always @(negedge clk) begin
      if (q.size() != 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (issue0 !== e.i0 || issue1 !== e.i1 || int_go !== e.ig ||
             int_from_young !== e.iy || fp_go !== e.fg || fp_from_young !== e.fy) begin
            fails++;
            $display("FAIL %s: got i0=%b i1=%b ig=%b iy=%b fg=%b fy=%b, expected i0=%b i1=%b ig=%b iy=%b fg=%b fy=%b",
                     e.tag, issue0, issue1, int_go, int_from_young, fp_go, fp_from_young,
                     e.i0, e.i1, e.ig, e.iy, e.fg, e.fy);
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      slot_t idle;
      idle = mk(0, 0, 0, 0, 0, 1);
      s0 = idle;
      s1 = idle;
      wb_valid = '0;
      wb_reg = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R10: fresh state, nothing presented
      step(idle, idle, 3'b000, 0, 0, 0, ex(0, 0, 2'b00, 2'b00, 0, 0, "R10 idle after reset"));
      // R8/R10: two integer ops, everything free
      step(mk(1, 1, 2, 3, 0, 1), mk(1, 4, 5, 6, 0, 1), 3'b000, 0, 0, 0,
           ex(1, 1, 2'b11, 2'b10, 0, 0, "R8 pair to both int units"));
      // R3: sources 1 and 4 released by same-cycle write-back
      step(mk(1, 7, 1, 4, 0, 1), mk(1, 8, 9, 10, 1, 3), 3'b011, 1, 4, 0,
           ex(1, 1, 2'b01, 2'b00, 1, 1, "R3 bypass, fp from younger"));
      // R4/R5: fp unit busy with a 3-cycle op
      step(mk(1, 11, 12, 13, 1, 1), mk(1, 14, 0, 0, 0, 1), 3'b001, 7, 0, 0,
           ex(0, 0, 2'b00, 2'b00, 0, 0, "R5 fp busy stalls pair"));
      // R2 stall on reg 8; R1 keeps the independent younger back
      step(mk(1, 15, 8, 0, 0, 1), mk(1, 16, 0, 0, 0, 1), 3'b000, 0, 0, 0,
           ex(0, 0, 2'b00, 2'b00, 0, 0, "R1 R2 raw stall blocks younger"));
      // R4: both want the fp unit
      step(mk(1, 8, 1, 2, 1, 2), mk(1, 16, 0, 0, 1, 1), 3'b001, 8, 0, 0,
           ex(1, 0, 2'b00, 2'b00, 1, 0, "R4 fp claimed by older"));
      // R6: reg 8 has 1 cycle left, new latency 1
      step(mk(1, 8, 0, 0, 0, 1), idle, 3'b000, 0, 0, 0,
           ex(0, 0, 2'b00, 2'b00, 0, 0, "R6 waw stall"));
      // R8/R9: both integer units again
      step(mk(1, 20, 0, 0, 0, 3), mk(1, 21, 0, 0, 0, 1), 3'b001, 8, 0, 0,
           ex(1, 1, 2'b11, 2'b10, 0, 0, "R9 two strobes for two issues"));
      // R6 longer latency passes; R8 skips busy unit 0
      step(mk(1, 20, 0, 0, 0, 3), mk(1, 22, 0, 0, 0, 1), 3'b001, 21, 0, 0,
           ex(1, 0, 2'b10, 2'b00, 0, 0, "R6 R8 waw longer issues on unit 1"));
      // R5: both integer units busy
      step(mk(1, 23, 0, 0, 0, 1), idle, 3'b000, 0, 0, 0,
           ex(0, 0, 2'b00, 2'b00, 0, 0, "R5 int units busy"));
      // R11: superseded writer's pulse for reg 20
      step(mk(1, 24, 20, 0, 0, 1), idle, 3'b001, 20, 0, 0,
           ex(0, 0, 2'b00, 2'b00, 0, 0, "R11 stale write-back keeps pending"));
      // R3 latest writer's pulse; R2 younger reads older dst
      step(mk(1, 24, 20, 0, 0, 1), mk(1, 25, 24, 0, 0, 1), 3'b001, 20, 0, 0,
           ex(1, 0, 2'b01, 2'b00, 0, 0, "R2 R3 intra-pair raw"));
      // R7: same dst, equal latency
      step(mk(1, 26, 0, 0, 0, 2), mk(1, 26, 0, 0, 0, 2), 3'b001, 24, 0, 0,
           ex(1, 0, 2'b01, 2'b00, 0, 0, "R7 intra-pair waw stall"));
      // R7: same dst, younger strictly longer
      step(mk(1, 27, 0, 0, 0, 1), mk(1, 27, 0, 0, 1, 3), 3'b000, 0, 0, 0,
           ex(1, 1, 2'b10, 2'b00, 1, 1, "R7 intra-pair waw longer issues"));
      // R11: older writer of 27 completes, younger still running
      step(mk(1, 28, 27, 0, 0, 1), idle, 3'b011, 26, 27, 0,
           ex(0, 0, 2'b00, 2'b00, 0, 0, "R11 reg 27 stays pending"));
      // R12: older slot empty
      step(idle, mk(1, 30, 0, 0, 0, 1), 3'b000, 0, 0, 0,
           ex(0, 0, 2'b00, 2'b00, 0, 0, "R12 no older instruction"));
      // R3: final write of 27 resolves the dependency
      step(mk(1, 29, 27, 26, 0, 1), idle, 3'b001, 27, 0, 0,
           ex(1, 0, 2'b01, 2'b00, 0, 0, "R3 latest writer releases"));

      @(posedge clk);
      #1;
      s0 = idle;
      s1 = idle;
      wb_valid = '0;
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule